// File: doc/BRIEF.md
# Tiled Tridiagonal Fixed-Point Solver

The block solves a diagonally dominant tridiagonal system A·x = y by nonpivoting Gaussian elimination in two passes. The coefficients stay in an external word-addressed memory. The block reads them one tile of `TILE` rows at a time into four small local buffers. Values are signed fixed point, `W` bits wide, with `FRAC` fractional bits. The system size `N_ROWS` must be a multiple of `TILE`, and `TILE` must be a power of two of at least 2.

The elimination pass walks the tiles from the lowest row upward. For each tile it loads the lower, main and upper coefficients and the right-hand side. It reduces the rows to upper-triangular form and writes the reduced pivots and the reduced right-hand side back over the originals. Three values carry from the last row of one tile into the first row of the next: the pivot, the right-hand side and the upper coefficient. The substitution pass then walks the tiles from the highest row downward. It reloads the reduced pivots, the upper coefficients and the reduced right-hand side, and writes the solution. The newest solution value carries downward across each tile boundary.

A host fills memory, pulses `start_i` and waits for `done_o`. The block allows only one read in flight. Writes take effect in the cycle they are issued.

Top module: `tds_solver`

## Requirements
- R1: After reset `busy_o`, `done_o` and `mem_req_o` are low. A `start_i` pulse while idle raises `busy_o` in the next cycle. `done_o` is a single-cycle pulse, after which `busy_o` is low.
- R2: Memory address is `v*N_ROWS + row`, where the region code v is 0 for lower, 1 for main, 2 for upper, 3 for right-hand side and 4 for solution.
- R3: The elimination pass visits tiles in ascending order. It writes only to regions 1 and 3, and every such write comes before any write to region 4.
- R4: The reduced values follow these rules. Row 0 keeps its main value and right-hand side. For row i>0, let w = l_i / d'_(i-1). Then d'_i = d_i − w·u_(i-1) and y'_i = y_i − w·y'_(i-1). A product is the full product arithmetically shifted right by `FRAC`. A quotient is (a·2^FRAC)/b truncated toward zero. Both results keep the low `W` bits.
- R5: The lower coefficient of row 0 and the upper coefficient of row `N_ROWS-1` have no effect on any result.
- R6: The substitution pass visits tiles in descending order and writes only to region 4.
- R7: x_(N-1) = y'_(N-1) / d'_(N-1). For every other row, x_i = (y'_i − u_i·x_(i+1)) / d'_i, using the same arithmetic as R4.
- R8: No new request is issued while a read is outstanding.
- R9: One solve issues exactly 7·N_ROWS reads and 3·N_ROWS writes.
- R10: `done_o` rises in the cycle right after the final solution write.
- R11: `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a solve when idle |
| busy_o | output | 1 | Solve in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | $clog2(5*N_ROWS) | Word address |
| mem_wdata_o | output | W | Write data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | W | Read data |

## Verification
Assertions check several rules on every cycle:
- no request while a read is outstanding;
- the single-cycle `done_o` pulse and its position right after a write;
- the write regions allowed in each pass;
- that `busy_o` does not drop on a stray start;
- that the divider is never restarted mid-division.

Only the bench scenarios can show the numeric results, which it compares row by row against an independent fixed-point reference. The same applies to the ascending and descending tile orders, the exact read and write counts, and the invariance of results to the two ignored corner coefficients.

// File: rtl/tds_pkg.sv
package tds_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FLOAD, ST_FCALC, ST_FSTORE,
    ST_BLOAD, ST_BCALC, ST_BSTORE, ST_DONE
  } state_e;

  // memory region codes; layout depends on this order
  localparam int unsigned VEC_L = 0;
  localparam int unsigned VEC_D = 1;
  localparam int unsigned VEC_U = 2;
  localparam int unsigned VEC_Y = 3;
  localparam int unsigned VEC_X = 4;
  localparam int unsigned N_VEC = 5;
endpackage

// File: rtl/tds_tile_buf.sv
module tds_tile_buf #(
  parameter int W     = 24,
  parameter int DEPTH = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic signed [W-1:0]      wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic signed [W-1:0]      rdata_o
);
  logic signed [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tds_fxdiv.sv
module tds_fxdiv #(
  parameter int W    = 24,
  parameter int FRAC = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic signed [W-1:0] num_i,
  input  logic signed [W-1:0] den_i,
  output logic                done_o,
  output logic signed [W-1:0] quo_o
);
  localparam int NB  = W + FRAC;
  localparam int CNW = $clog2(NB + 1);

  logic           busy_q, done_q, neg_q;
  logic [NB-1:0]  dvd_q, quo_q;
  logic [W-1:0]   rem_q, den_q;
  logic [CNW-1:0] cnt_q;

  logic [W-1:0] num_mag, den_mag;
  logic [W:0]   rem_sh;
  logic         ge;

  assign num_mag = num_i[W-1] ? W'(-num_i) : W'(num_i);
  assign den_mag = den_i[W-1] ? W'(-den_i) : W'(den_i);
  assign rem_sh  = {rem_q, dvd_q[NB-1]};
  assign ge      = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      neg_q  <= 1'b0;
      dvd_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        neg_q  <= num_i[W-1] ^ den_i[W-1];
        dvd_q  <= {num_mag, {FRAC{1'b0}}};
        den_q  <= den_mag;
        rem_q  <= '0;
        quo_q  <= '0;
        cnt_q  <= CNW'(NB);
      end else if (busy_q) begin
        dvd_q <= {dvd_q[NB-2:0], 1'b0};
        rem_q <= ge ? W'(rem_sh - {1'b0, den_q}) : rem_sh[W-1:0];
        quo_q <= {quo_q[NB-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = neg_q ? -$signed(quo_q[W-1:0]) : $signed(quo_q[W-1:0]);

  // R4
  div_start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/tds_solver.sv
module tds_solver
  import tds_pkg::*;
#(
  parameter int W      = 24,
  parameter int FRAC   = 16,
  parameter int N_ROWS = 16,
  parameter int TILE   = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          mem_req_o,
  output logic                          mem_we_o,
  output logic [$clog2(5*N_ROWS)-1:0]   mem_addr_o,
  output logic [W-1:0]                  mem_wdata_o,
  input  logic                          mem_rvalid_i,
  input  logic [W-1:0]                  mem_rdata_i
);
  localparam int N_TILES = N_ROWS / TILE;
  localparam int AW      = $clog2(N_VEC * N_ROWS);
  localparam int RW      = $clog2(TILE);
  localparam int TW      = (N_TILES > 1) ? $clog2(N_TILES) : 1;
  localparam int GW      = TW + RW;
  localparam int CW      = $clog2(4 * TILE);

  function automatic logic signed [W-1:0] fmul(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] b);
    logic signed [2*W-1:0] p;
    p = a * b;
    return p[FRAC+W-1:FRAC];
  endfunction

  state_e              state_q;
  logic [TW-1:0]       tile_q;
  logic [CW-1:0]       cnt_q;
  logic [RW-1:0]       row_q;
  logic                rd_wait_q, div_wait_q;
  logic signed [W-1:0] dprev_q, yprev_q, uprev_q, xnext_q;

  logic                fwd_phase, is_load, is_store, ld_last, first_row, last_row;
  logic [1:0]          ld_vec;
  logic [2:0]          vec_sel;
  logic [RW-1:0]       cur_row;
  logic [GW-1:0]       g_row;
  logic [3:0]          buf_we;
  logic signed [W-1:0] buf_wd [4];
  logic signed [W-1:0] buf_rd [4];
  logic                div_start, div_done;
  logic signed [W-1:0] div_num, div_den, div_q, dp, yp;

  assign fwd_phase = state_q inside {ST_FLOAD, ST_FCALC, ST_FSTORE};
  assign is_load   = state_q inside {ST_FLOAD, ST_BLOAD};
  assign is_store  = state_q inside {ST_FSTORE, ST_BSTORE};
  assign ld_vec    = fwd_phase ? cnt_q[CW-1:RW] : cnt_q[CW-1:RW] + 2'd1;
  assign ld_last   = cnt_q == (fwd_phase ? CW'(4*TILE-1) : CW'(3*TILE-1));
  assign cur_row   = (is_load || is_store) ? cnt_q[RW-1:0] : row_q;
  assign g_row     = {tile_q, cur_row};
  assign first_row = g_row == '0;
  assign last_row  = g_row == GW'(N_ROWS-1);
  assign dp        = buf_rd[VEC_D] - fmul(div_q, uprev_q);
  assign yp        = buf_rd[VEC_Y] - fmul(div_q, yprev_q);

  for (genvar b = 0; b < 4; b++) begin : g_buf
    tds_tile_buf #(.W(W), .DEPTH(TILE)) u_buf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (buf_we[b]),
      .waddr_i (cur_row),
      .wdata_i (buf_wd[b]),
      .raddr_i (cur_row),
      .rdata_o (buf_rd[b])
    );
  end

  tds_fxdiv #(.W(W), .FRAC(FRAC)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (div_num),
    .den_i   (div_den),
    .done_o  (div_done),
    .quo_o   (div_q)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    vec_sel     = 3'd0;
    buf_we      = '0;
    for (int b = 0; b < 4; b++) buf_wd[b] = $signed(mem_rdata_i);
    div_start   = 1'b0;
    div_num     = '0;
    div_den     = '0;
    case (state_q)
      ST_FLOAD, ST_BLOAD: begin
        vec_sel   = {1'b0, ld_vec};
        mem_req_o = !rd_wait_q;
        if (rd_wait_q && mem_rvalid_i) buf_we[ld_vec] = 1'b1;
      end
      ST_FCALC: begin
        div_num = buf_rd[VEC_L];
        div_den = dprev_q;
        if (!div_wait_q && !first_row) div_start = 1'b1;
        if (div_wait_q && div_done) begin
          buf_we[VEC_D] = 1'b1;
          buf_we[VEC_Y] = 1'b1;
          buf_wd[VEC_D] = dp;
          buf_wd[VEC_Y] = yp;
        end
      end
      ST_FSTORE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        vec_sel     = (cnt_q < CW'(TILE)) ? 3'(VEC_D) : 3'(VEC_Y);
        mem_wdata_o = (cnt_q < CW'(TILE)) ? buf_rd[VEC_D] : buf_rd[VEC_Y];
      end
      ST_BCALC: begin
        // upper of last row treated as zero
        div_num = last_row ? buf_rd[VEC_Y] : buf_rd[VEC_Y] - fmul(buf_rd[VEC_U], xnext_q);
        div_den = buf_rd[VEC_D];
        if (!div_wait_q) div_start = 1'b1;
        if (div_wait_q && div_done) begin
          buf_we[VEC_Y] = 1'b1;
          buf_wd[VEC_Y] = div_q;
        end
      end
      ST_BSTORE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        vec_sel     = 3'(VEC_X);
        mem_wdata_o = buf_rd[VEC_Y];
      end
      default: ;
    endcase
  end

  assign mem_addr_o = AW'(vec_sel) * AW'(N_ROWS) + AW'(g_row);
  assign busy_o     = state_q != ST_IDLE;
  assign done_o     = state_q == ST_DONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tile_q     <= '0;
      cnt_q      <= '0;
      row_q      <= '0;
      rd_wait_q  <= 1'b0;
      div_wait_q <= 1'b0;
      dprev_q    <= '0;
      yprev_q    <= '0;
      uprev_q    <= '0;
      xnext_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          tile_q    <= '0;
          cnt_q     <= '0;
          rd_wait_q <= 1'b0;
          state_q   <= ST_FLOAD;
        end
        ST_FLOAD, ST_BLOAD: begin
          if (!rd_wait_q) rd_wait_q <= 1'b1;
          else if (mem_rvalid_i) begin
            rd_wait_q <= 1'b0;
            if (ld_last) begin
              cnt_q   <= '0;
              row_q   <= fwd_phase ? '0 : RW'(TILE-1);
              state_q <= fwd_phase ? ST_FCALC : ST_BCALC;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FCALC: begin
          if (!div_wait_q && !first_row) div_wait_q <= 1'b1;
          else if (first_row || div_done) begin
            dprev_q    <= first_row ? buf_rd[VEC_D] : dp;
            yprev_q    <= first_row ? buf_rd[VEC_Y] : yp;
            uprev_q    <= buf_rd[VEC_U];
            div_wait_q <= 1'b0;
            if (row_q == RW'(TILE-1)) begin
              cnt_q   <= '0;
              state_q <= ST_FSTORE;
            end else row_q <= row_q + 1'b1;
          end
        end
        ST_FSTORE: begin
          if (cnt_q == CW'(2*TILE-1)) begin
            cnt_q <= '0;
            if (tile_q == TW'(N_TILES-1)) state_q <= ST_BLOAD;
            else begin
              tile_q  <= tile_q + 1'b1;
              state_q <= ST_FLOAD;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_BCALC: begin
          if (!div_wait_q) div_wait_q <= 1'b1;
          else if (div_done) begin
            xnext_q    <= div_q;
            div_wait_q <= 1'b0;
            if (row_q == '0) begin
              cnt_q   <= '0;
              state_q <= ST_BSTORE;
            end else row_q <= row_q - 1'b1;
          end
        end
        ST_BSTORE: begin
          if (cnt_q == CW'(TILE-1)) begin
            cnt_q <= '0;
            if (tile_q == '0) state_q <= ST_DONE;
            else begin
              tile_q  <= tile_q - 1'b1;
              state_q <= ST_BLOAD;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // read tracker built from port activity only
  logic rd_pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_pend_q <= 1'b0;
    else if (mem_req_o && !mem_we_o) rd_pend_q <= 1'b1;
    else if (mem_rvalid_i) rd_pend_q <= 1'b0;
  end

  localparam logic [AW-1:0] A_D = AW'(VEC_D * N_ROWS);
  localparam logic [AW-1:0] A_U = AW'(VEC_U * N_ROWS);
  localparam logic [AW-1:0] A_Y = AW'(VEC_Y * N_ROWS);
  localparam logic [AW-1:0] A_X = AW'(VEC_X * N_ROWS);

  // R8
  one_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend_q |-> !mem_req_o);
  // R1
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  // R10
  done_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_we_o && mem_addr_o >= A_X));
  // R3
  fwd_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && fwd_phase) |->
      ((mem_addr_o >= A_D && mem_addr_o < A_U) || (mem_addr_o >= A_Y && mem_addr_o < A_X)));
  // R6
  back_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !fwd_phase) |-> mem_addr_o >= A_X);
  // R11
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);
endmodule

// File: tb/tds_solver_test.sv
`timescale 1ns/1ps
module tds_solver_test;
  localparam int W = 24, FRAC = 16, N = 16, T = 4;
  localparam int AW = $clog2(5*N);
  // scenario table: {seed, read latency, mode}
  // mode 0 plain, 1 corner garbage (R5), 2 stray start (R11), 3 weak dominance, 4 negative pivots
  localparam logic [39:0] SCEN [5] = '{
    {32'h1234_5678, 4'd1, 4'd0},
    {32'h0BAD_F00D, 4'd3, 4'd1},
    {32'h5EED_0001, 4'd2, 4'd2},
    {32'h0000_C0DE, 4'd1, 4'd3},
    {32'hFACE_0042, 4'd2, 4'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, req, we, rvalid = 1'b0;
  logic [AW-1:0] addr;
  logic [W-1:0] wdata, rdata = '0;

  always #2 clk = ~clk;

  tds_solver #(.W(W), .FRAC(FRAC), .N_ROWS(N), .TILE(T)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata)
  );

  logic [W-1:0] mem [5*N];
  longint exp_d [N], exp_y [N], exp_x [N];
  int checks = 0, errors = 0, lat_cfg = 1, cyc = 0;
  int reads, writes, last_w, done_cyc, fwd_err, back_err, last_ft, last_xt;
  bit seen_x, finished = 1'b0;
  longint unsigned lcg;

  // memory model, acts mid-cycle
  initial begin
    int wcnt = 0, raddr = 0;
    forever begin
      @(negedge clk);
      cyc++;
      rvalid = 1'b0;
      if (wcnt > 0) begin
        wcnt--;
        if (wcnt == 0) begin rvalid = 1'b1; rdata = mem[raddr]; end
      end
      if (done) done_cyc = cyc;
      if (req) begin
        if (we) begin
          int v, t;
          v = int'(addr) / N;
          t = (int'(addr) % N) / T;
          writes++;
          mem[addr] = wdata;
          last_w = cyc;
          if (v == 1 || v == 3) begin
            if (seen_x || t < last_ft) fwd_err++;
            last_ft = t;
          end else if (v == 4) begin
            if (t > last_xt) back_err++;
            seen_x = 1'b1;
            last_xt = t;
          end else fwd_err++;
        end else begin
          reads++;
          raddr = int'(addr);
          wcnt = lat_cfg;
        end
      end
    end
  end

  function automatic longint sx(input longint v);
    logic [W-1:0] t;
    t = v[W-1:0];
    return longint'($signed(t));
  endfunction
  function automatic longint fmul_r(input longint a, input longint b);
    return sx((a * b) >>> FRAC);
  endfunction
  function automatic longint fdiv_r(input longint a, input longint b);
    return sx((a * 65536) / b);
  endfunction
  function automatic longint rnd(input longint range);
    lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
    return longint'(lcg >> 33) % range;
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  task automatic gen(input logic [31:0] seed, input int mode);
    lcg = 64'(seed);
    for (int i = 0; i < N; i++) begin
      longint offr, dv;
      offr = (mode == 3) ? 124000 : 98000;
      dv = (mode == 3) ? 262144 + rnd(13000) : 262144 + rnd(131072);
      if (mode == 4) dv = -dv;
      mem[i]       = W'(rnd(offr) - offr / 2);
      mem[N + i]   = W'(dv);
      mem[2*N + i] = W'(rnd(offr) - offr / 2);
      mem[3*N + i] = W'(rnd(524288) - 262144);
      mem[4*N + i] = W'(24'hABCDE);
    end
    if (mode == 1) begin
      mem[0]       = 24'h7FFFFF;
      mem[3*N - 1] = 24'h800001;
    end
  endtask

  // independent reference solve (R4, R5, R7)
  task automatic ref_solve();
    for (int i = 0; i < N; i++) begin
      longint d, y;
      d = sx(longint'(mem[N + i]));
      y = sx(longint'(mem[3*N + i]));
      if (i == 0) begin
        exp_d[i] = d; exp_y[i] = y;
      end else begin
        longint w;
        w = fdiv_r(sx(longint'(mem[i])), exp_d[i-1]);
        exp_d[i] = sx(d - fmul_r(w, sx(longint'(mem[2*N + i - 1]))));
        exp_y[i] = sx(y - fmul_r(w, exp_y[i-1]));
      end
    end
    for (int i = N - 1; i >= 0; i--) begin
      longint num;
      num = (i == N - 1) ? exp_y[i]
                         : sx(exp_y[i] - fmul_r(sx(longint'(mem[2*N + i])), exp_x[i+1]));
      exp_x[i] = fdiv_r(num, exp_d[i]);
    end
  endtask

  task automatic run(input int mode);
    reads = 0; writes = 0; last_w = 0; done_cyc = 0;
    fwd_err = 0; back_err = 0; last_ft = 0; last_xt = N; seen_x = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", longint'(busy), 1);
    if (mode == 2) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R11 busy kept on stray start", longint'(busy), 1);
    end
    while (done_cyc == 0) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R1 done pulse ends idle", longint'({done, busy}), 0);
    chk(done_cyc == last_w + 1, "R10 done after last write", done_cyc, last_w + 1);
    chk(reads == 7*N, (mode == 2) ? "R11 R9 reads" : "R9 reads", reads, 7*N);
    chk(writes == 3*N, "R9 writes", writes, 3*N);
    chk(fwd_err == 0, "R3 elimination order/region", fwd_err, 0);
    chk(back_err == 0, "R6 substitution order", back_err, 0);
    for (int i = 0; i < N; i++) begin
      chk(sx(longint'(mem[N + i])) == exp_d[i], "R4 reduced pivot (R2 layout)",
          sx(longint'(mem[N + i])), exp_d[i]);
      chk(sx(longint'(mem[3*N + i])) == exp_y[i], "R4 reduced rhs",
          sx(longint'(mem[3*N + i])), exp_y[i]);
      chk(sx(longint'(mem[4*N + i])) == exp_x[i], (mode == 1) ? "R5 R7 solution" : "R7 solution",
          sx(longint'(mem[4*N + i])), exp_x[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && req == 1'b0, "R1 reset state",
        longint'({busy, done, req}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int s = 0; s < 5; s++) begin
      lat_cfg = int'(SCEN[s][7:4]);
      gen(SCEN[s][39:8], int'(SCEN[s][3:0]));
      ref_solve();
      run(int'(SCEN[s][3:0]));
    end

    // identity system: x equals y exactly (R7)
    lat_cfg = 1;
    for (int i = 0; i < N; i++) begin
      mem[i] = '0; mem[N + i] = 24'h010000; mem[2*N + i] = '0;
      mem[3*N + i] = W'(i * 1000 - 5000); mem[4*N + i] = '0;
    end
    ref_solve();
    run(0);
    for (int i = 0; i < N; i++)
      chk(sx(longint'(mem[4*N + i])) == longint'(i * 1000 - 5000), "R7 identity",
          sx(longint'(mem[4*N + i])), longint'(i * 1000 - 5000));

    // reset mid-solve then recover (R1)
    gen(32'h0000_7777, 0);
    ref_solve();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && req == 1'b0, "R1 reset mid-run", longint'({busy, req}), 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    gen(32'h0000_7777, 0);
    ref_solve();
    run(0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule